// File: doc/BRIEF.md
# Processor Run-State Supervisor

This block keeps track of the top-level run state of a processor core. It accepts single-cycle event inputs from the rest of the core and reports one of four states: exception sequencing, normal execution, stopped (normal execution with no bus traffic) and halted. The stacking, vector fetch and pipe refill of an exception are done by surrounding logic. This block starts that work with a one-cycle start pulse and learns that it has finished when the first handler instruction starts.

A fault (bus error or address error) during normal execution starts exception sequencing. The same fault while exception sequencing is still in progress is treated as catastrophic: the block halts and asserts a halt output that blocks all further bus activity. Only the asynchronous reset clears the halt. Reset itself begins exception sequencing, so that the reset vector is fetched.

Top module: `proc_state_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, state_o is 2'b00 (exception sequencing), exc_start_o is 1, halt_o is 0 and stop_o is 0. State codes: 2'b00 exception sequencing, 2'b01 normal, 2'b10 stopped, 2'b11 halted.
- R2: In exception sequencing, handler_start_i with no fault input moves the state to normal at the next clock edge.
- R3: In normal state, exc_req_i, bus_err_i or addr_err_i moves the state to exception sequencing at the next edge, and exc_start_o is high for exactly the first cycle in that state.
- R4: In exception sequencing, bus_err_i or addr_err_i moves the state to halted at the next edge. This holds even when handler_start_i is high in the same cycle.
- R5: Once halted, the state stays halted and halt_o stays 1 whatever the event inputs do. Only rst_ni leaves the state, and it leads to exception sequencing.
- R6: In normal state, stop_exec_i with no exception or fault moves the state to stopped, with stop_o 1 and halt_o 0.
- R7: In stopped state, wake_i moves the state to exception sequencing with an exc_start_o pulse. All other event inputs leave the state stopped.
- R8: In normal state, an exception or fault in the same cycle as stop_exec_i wins: the next state is exception sequencing.
- R9: In exception sequencing, exc_req_i has no effect: the state stays in exception sequencing and no further exc_start_o pulse is produced.
- R10: halt_o is 1 exactly when the state is halted, stop_o is 1 exactly when the state is stopped, and the two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low external reset |
| exc_req_i | input | 1 | Exception request (interrupt acknowledge, trace, trap, other) |
| bus_err_i | input | 1 | Bus cycle ended with a bus error |
| addr_err_i | input | 1 | Address error detected |
| stop_exec_i | input | 1 | Stop instruction executed |
| wake_i | input | 1 | Interrupt or trace pending while stopped |
| handler_start_i | input | 1 | First handler instruction begins execution |
| state_o | output | 2 | Current run state code |
| halt_o | output | 1 | Halted; blocks further bus activity |
| stop_o | output | 1 | Stopped; normal state with no bus cycles |
| exc_start_o | output | 1 | One-cycle pulse starting exception sequencing |

## Verification
Two pairs of events can arrive in the same cycle. In exception sequencing, a fault can coincide with the handler-start event. In normal state, an exception request can coincide with a stop instruction. The bench raises both inputs of each pair on the same edge. It then reads state_o and the halt and stop flags at the next falling edge, and expects halted in the first case and exception sequencing with a fresh start pulse in the second.

// File: rtl/psc_pkg.sv
package psc_pkg;
  typedef enum logic [1:0] {
    PS_EXC  = 2'b00,
    PS_NORM = 2'b01,
    PS_STOP = 2'b10,
    PS_HALT = 2'b11
  } pstate_e;

  typedef struct packed {
    logic exc_req;
    logic fault;
    logic stop;
    logic wake;
    logic hstart;
  } evt_t;
endpackage

// File: rtl/psc_next.sv
module psc_next
  import psc_pkg::*;
(
  input  pstate_e state_i,
  input  evt_t    evt_i,
  output pstate_e nxt_o,
  output logic    enter_exc_o
);
  always_comb begin
    nxt_o = state_i;
    unique case (state_i)
      PS_EXC: begin
        // fault outranks handler start
        if (evt_i.fault)       nxt_o = PS_HALT;
        else if (evt_i.hstart) nxt_o = PS_NORM;
      end
      PS_NORM: begin
        if (evt_i.fault || evt_i.exc_req) nxt_o = PS_EXC;
        else if (evt_i.stop)              nxt_o = PS_STOP;
      end
      PS_STOP: begin
        if (evt_i.wake) nxt_o = PS_EXC;
      end
      default: nxt_o = PS_HALT;
    endcase
    enter_exc_o = (nxt_o == PS_EXC) && (state_i != PS_EXC);
  end
endmodule

// File: rtl/psc_state_reg.sv
module psc_state_reg
  import psc_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  pstate_e nxt_i,
  input  logic    enter_exc_i,
  output pstate_e state_o,
  output logic    first_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= PS_EXC;
      first_o <= 1'b1;
    end else begin
      state_o <= nxt_i;
      first_o <= enter_exc_i;
    end
  end
endmodule

// File: rtl/psc_out.sv
module psc_out
  import psc_pkg::*;
(
  input  pstate_e    state_i,
  input  logic       first_i,
  output logic [1:0] state_o,
  output logic       halt_o,
  output logic       stop_o,
  output logic       exc_start_o
);
  always_comb begin
    state_o     = state_i;
    halt_o      = (state_i == PS_HALT);
    stop_o      = (state_i == PS_STOP);
    exc_start_o = first_i && (state_i == PS_EXC);
  end
endmodule

// File: rtl/proc_state_ctrl.sv
module proc_state_ctrl
  import psc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       exc_req_i,
  input  logic       bus_err_i,
  input  logic       addr_err_i,
  input  logic       stop_exec_i,
  input  logic       wake_i,
  input  logic       handler_start_i,
  output logic [1:0] state_o,
  output logic       halt_o,
  output logic       stop_o,
  output logic       exc_start_o
);
  evt_t    evt;
  pstate_e state_q;
  pstate_e nxt;
  logic    enter_exc;
  logic    first_q;

  always_comb begin
    evt.exc_req = exc_req_i;
    evt.fault   = bus_err_i | addr_err_i;
    evt.stop    = stop_exec_i;
    evt.wake    = wake_i;
    evt.hstart  = handler_start_i;
  end

  psc_next u_next (
    .state_i     (state_q),
    .evt_i       (evt),
    .nxt_o       (nxt),
    .enter_exc_o (enter_exc)
  );

  psc_state_reg u_reg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .nxt_i       (nxt),
    .enter_exc_i (enter_exc),
    .state_o     (state_q),
    .first_o     (first_q)
  );

  psc_out u_out (
    .state_i     (state_q),
    .first_i     (first_q),
    .state_o     (state_o),
    .halt_o      (halt_o),
    .stop_o      (stop_o),
    .exc_start_o (exc_start_o)
  );
endmodule

// File: rtl/proc_state_ctrl_chk.sv
module proc_state_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       exc_req_i,
  input logic       bus_err_i,
  input logic       addr_err_i,
  input logic       stop_exec_i,
  input logic       wake_i,
  input logic       handler_start_i,
  input logic [1:0] state_o,
  input logic       halt_o,
  input logic       stop_o,
  input logic       exc_start_o
);
  localparam logic [1:0] S_EXC  = 2'b00;
  localparam logic [1:0] S_NORM = 2'b01;
  localparam logic [1:0] S_STOP = 2'b10;

  p_start_norm_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == S_EXC && !bus_err_i && !addr_err_i && handler_start_i) |=> (state_o == S_NORM));

  p_pulse_once_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_start_o |=> !exc_start_o);

  p_fault_halt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == S_EXC && (bus_err_i || addr_err_i)) |=> halt_o);

  p_halt_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o);

  p_stop_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == S_STOP && !wake_i) |=> (state_o == S_STOP));

  p_exc_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == S_NORM && exc_req_i && stop_exec_i) |=> (state_o == S_EXC && exc_start_o));

  p_no_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == S_EXC && !bus_err_i && !addr_err_i && !handler_start_i) |=> (state_o == S_EXC && !exc_start_o));

  p_flags_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(halt_o && stop_o));
endmodule

bind proc_state_ctrl proc_state_ctrl_chk u_chk (.*);

// File: tb/sim_proc_state_ctrl.sv
`timescale 1ns/1ps
module sim_proc_state_ctrl;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic exc_req_i = 0, bus_err_i = 0, addr_err_i = 0;
  logic stop_exec_i = 0, wake_i = 0, handler_start_i = 0;
  logic [1:0] state_o;
  logic halt_o, stop_o, exc_start_o;
  int checks = 0;
  int errors = 0;

  localparam logic [5:0] E_EXC = 6'b100000, E_BERR = 6'b010000, E_AERR = 6'b001000,
                         E_STOP = 6'b000100, E_WAKE = 6'b000010, E_HS = 6'b000001;
  localparam logic [1:0] S_EXC = 2'b00, S_NORM = 2'b01, S_STOP = 2'b10, S_HALT = 2'b11;

  always #10 clk_i = ~clk_i;

  proc_state_ctrl u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expects to be called at a falling edge; outputs valid on return
  task automatic ev(input logic [5:0] e);
    {exc_req_i, bus_err_i, addr_err_i, stop_exec_i, wake_i, handler_start_i} = e;
    @(negedge clk_i);
    {exc_req_i, bus_err_i, addr_err_i, stop_exec_i, wake_i, handler_start_i} = '0;
  endtask

  task automatic look(input string req, input logic [1:0] st, input logic h, input logic s, input logic p);
    chk({req, " state"}, state_o, st);
    chk({req, " halt"}, halt_o, h);
    chk({req, " stop"}, stop_o, s);
    chk({req, " start"}, exc_start_o, p);
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    rst_ni = 1'b0;
    #3;
    look("R1 in reset", S_EXC, 0, 0, 1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    look("R1 released", S_EXC, 0, 0, 1);
    @(negedge clk_i);
    look("R1 after edge", S_EXC, 0, 0, 0);
  endtask

  task automatic t_exc_entry;
    ev(E_HS);   look("R2 to normal", S_NORM, 0, 0, 0);
    ev(E_EXC);  look("R3 exc req", S_EXC, 0, 0, 1);
    ev(6'b0);   look("R3 pulse ends", S_EXC, 0, 0, 0);
    ev(E_EXC);  look("R9 ignored", S_EXC, 0, 0, 0);
    ev(E_HS);   look("R2 again", S_NORM, 0, 0, 0);
    ev(E_BERR); look("R3 bus err", S_EXC, 0, 0, 1);
    ev(E_HS);   look("R2 third", S_NORM, 0, 0, 0);
    ev(E_AERR); look("R3 addr err", S_EXC, 0, 0, 1);
    ev(E_HS);   look("R2 fourth", S_NORM, 0, 0, 0);
  endtask

  task automatic t_stop;
    ev(E_STOP); look("R6 stop", S_STOP, 0, 1, 0);
    ev(E_EXC);  look("R7 exc ignored", S_STOP, 0, 1, 0);
    ev(E_BERR | E_AERR); look("R7 fault ignored", S_STOP, 0, 1, 0);
    ev(E_HS | E_STOP);   look("R7 others ignored", S_STOP, 0, 1, 0);
    ev(E_WAKE); look("R7 wake", S_EXC, 0, 0, 1);
    ev(E_HS);   look("R2 after wake", S_NORM, 0, 0, 0);
  endtask

  task automatic t_prio;
    ev(E_EXC | E_STOP);  look("R8 exc beats stop", S_EXC, 0, 0, 1);
    ev(E_HS);            look("R2 back", S_NORM, 0, 0, 0);
    ev(E_BERR | E_STOP); look("R8 fault beats stop", S_EXC, 0, 0, 1);
  endtask

  task automatic t_halt;
    ev(E_BERR | E_HS); look("R4 fault with hstart", S_HALT, 1, 0, 0);
    ev(E_HS);   look("R5 hstart ignored", S_HALT, 1, 0, 0);
    ev(E_EXC | E_WAKE); look("R5 exc ignored", S_HALT, 1, 0, 0);
    ev(E_STOP | E_AERR); look("R10 halt only", S_HALT, 1, 0, 0);
    t_reset();
    ev(E_AERR); look("R4 addr err", S_HALT, 1, 0, 0);
    t_reset();
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_exc_entry();
    t_stop();
    t_prio();
    t_halt();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule